// File: doc/BRIEF.md
# Counting Semaphore Storage Cell

This block is one storage cell that threads use to synchronize through a counting semaphore. It sits behind the same set of access views as a queue cell, so an address decoder upstream only has to pass along a strobe, a read/write flag, a 3-bit view code, the ID of the requester and the write data. A read through one of the two semaphore views is a P (acquire) operation: it returns the count as it was and takes one from it. A write through either semaphore view is a V (release) operation: it adds one to the count and releases every requester that is waiting.

A P through the waiting view that finds the count at zero does not complete. The block raises a stall in the same cycle and records the requester in a per-requester blocked mask. A P through the try view on zero returns zero and never stalls. A V clears the mask and pulses one wake line per released requester for one cycle, so each requester can retry. The count saturates at its all-ones value. The tag view reads and writes three free tag bits in the queue cell's layout, with the queue-type flag reading as zero. The raw view reads the count without side effects. The queue views are inert on this cell.

Top module: `sem_cell`

## Requirements
- R1: A read through view 4 or view 5 returns the count before the access, zero-extended, and lowers the count by one when that count is above zero.
- R2: A read through view 4 (waiting P) with a count of zero drives `rsp_stall` high in that cycle, leaves the count unchanged, and sets bit `req_id` of `blocked_mask` from the next cycle on, keeping the bits already set.
- R3: A read through view 5 (try P) with a count of zero returns zero, keeps `rsp_stall` low and leaves `blocked_mask` unchanged.
- R4: A write through view 4 or view 5 (V) adds one to the count whatever the write data, and a V at the all-ones count (0xFFFF by default) leaves it there.
- R5: In the cycle after a V, `blocked_mask` is zero and `wake_pulse` equals the mask as it was before the V, for exactly that one cycle; `wake_pulse` is zero in any cycle that does not follow a V.
- R6: Reads through view 2 or view 3 (queue views) return zero without stall, and writes through them change neither the count, the tag bits nor the blocked mask.
- R7: A read through view 0 (raw) returns the count without changing it, and a write through view 0 changes nothing.
- R8: A read through view 1 (tag) returns T in bit 16, F in bit 1, E in bit 0 and zero in every other bit, bit 17 (the queue-type flag) included; a write through view 1 loads T, F and E from bits 16, 1 and 0 of the data.
- R9: After reset the count, the T, E and F bits, `blocked_mask` and `wake_pulse` are all zero.
- R10: A read through view 6 or view 7 returns all ones without stall, and a write through them changes nothing.
- R11: While `req_valid` is low or `req_write` is high, `rsp_rdata` is zero and `rsp_stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 3 | View code: 0 raw, 1 tag, 2/3 queue, 4 waiting P/V, 5 try P/V |
| req_id | input | ID_W | Requester number |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| rsp_stall | output | 1 | The read in this cycle must block |
| blocked_mask | output | NUM_REQ | One bit per waiting requester |
| wake_pulse | output | NUM_REQ | One-cycle release of the requesters waiting at a V |

## Verification
A wrong count shows at the ports only when it is read: the next raw or P read returns the wrong value, and a count stuck at zero also turns a waiting P into a stall. A wrong blocked mask shows directly on `blocked_mask` one cycle after the access that spoiled it, and a wrong release shows on `wake_pulse` in the single cycle after the V. The sweeps therefore read the count back after every kind of access, walk every requester into the mask and drive the count across its saturation point in a narrowed configuration, so a fault surfaces within one or two accesses of its cause.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

   typedef enum logic [2:0] {
      VW_RAW      = 3'd0,
      VW_TAG      = 3'd1,
      VW_Q_WAIT   = 3'd2,
      VW_Q_TRY    = 3'd3,
      VW_SEM_WAIT = 3'd4,
      VW_SEM_TRY  = 3'd5
   } sem_view_e;

   // tag word bit positions, shared with the queue cell
   localparam int unsigned TAG_E_POS    = 0;
   localparam int unsigned TAG_F_POS    = 1;
   localparam int unsigned TAG_T_POS    = 16;
   localparam int unsigned TAG_TYPE_POS = 17;

   typedef struct packed {
      logic t;
      logic f;
      logic e;
   } sem_tag_t;

endpackage

// File: rtl/sem_counter.sv
module sem_counter #(
   parameter int unsigned COUNT_W  = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inc,
   input  logic               dec,
   output logic [COUNT_W-1:0] count
);
   localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

   logic at_cap;

   generate
      if (COUNT_W < 2) begin : g_bad_width
         $error("sem_counter: COUNT_W must be at least 2");
      end
      if (SATURATE) begin : g_sat
         assign at_cap = (count == CNT_MAX);
      end else begin : g_wrap
         assign at_cap = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (inc) begin
         if (!at_cap) count <= count + 1'b1;
      end else if (dec) begin
         count <= count - 1'b1;
      end
   end

   AST_INC_DEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && dec)); // R1
   AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |=> (count == $past(count) - 1'b1)); // R1
   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && $past(1'b1) && count != CNT_MAX) |=> (count == $past(count) + 1'b1)); // R4

   generate
      if (SATURATE) begin : g_sat_chk
         AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && count == CNT_MAX) |=> (count == CNT_MAX)); // R4
      end
   endgenerate

endmodule

// File: rtl/sem_waitlist.sv
module sem_waitlist #(
   parameter int unsigned NUM_REQ = 8,
   localparam int unsigned ID_W   = $clog2(NUM_REQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               block_en,
   input  logic [ID_W-1:0]    block_id,
   input  logic               wake_all,
   output logic [NUM_REQ-1:0] mask,
   output logic [NUM_REQ-1:0] wake
);

   generate
      if (NUM_REQ < 2) begin : g_bad_req
         $error("sem_waitlist: NUM_REQ must be at least 2");
      end
      for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
         logic hit;
         assign hit = block_en && (block_id == ID_W'(i));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mask[i] <= 1'b0;
               wake[i] <= 1'b0;
            end else begin
               wake[i] <= wake_all && mask[i];
               if (wake_all)  mask[i] <= 1'b0;
               else if (hit)  mask[i] <= 1'b1;
            end
         end
      end
   endgenerate

   AST_BLOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (block_en && !wake_all) |=> mask[$past(block_id)]); // R2
   AST_BLOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake_all) |=> ((mask & $past(mask)) == $past(mask))); // R2
   AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      wake_all |=> (mask == '0 && wake == $past(mask))); // R5
   AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake_all) |=> (wake == '0)); // R5

endmodule

// File: rtl/sem_cell.sv
module sem_cell
   import sem_cell_pkg::*;
#(
   parameter int unsigned  COUNT_W  = 16,
   parameter int unsigned  DATA_W   = 32,
   parameter int unsigned  NUM_REQ  = 8,
   parameter bit           SATURATE = 1'b1,
   localparam int unsigned ID_W     = $clog2(NUM_REQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [2:0]         req_view,
   input  logic [ID_W-1:0]    req_id,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               rsp_stall,
   output logic [NUM_REQ-1:0] blocked_mask,
   output logic [NUM_REQ-1:0] wake_pulse
);

   generate
      if (DATA_W < TAG_TYPE_POS + 1) begin : g_bad_data
         $error("sem_cell: DATA_W too narrow for the tag word");
      end
      if (COUNT_W > DATA_W) begin : g_bad_count
         $error("sem_cell: COUNT_W must not exceed DATA_W");
      end
   endgenerate

   logic               rd, wr, sem_view;
   logic               do_p, do_v, p_dec, p_block;
   logic [COUNT_W-1:0] count;
   sem_tag_t           tag_q;
   logic [DATA_W-1:0]  tag_word;
   logic               wdata_unused;

   assign rd       = req_valid && !req_write;
   assign wr       = req_valid &&  req_write;
   assign sem_view = (req_view == VW_SEM_WAIT) || (req_view == VW_SEM_TRY);
   assign do_p     = rd && sem_view;
   assign do_v     = wr && sem_view;
   assign p_dec    = do_p && (count != '0);
   assign p_block  = do_p && (req_view == VW_SEM_WAIT) && (count == '0);

   // V ignores its data; only three tag bits are ever taken from it
   assign wdata_unused = ^req_wdata;

   sem_counter #(
      .COUNT_W  (COUNT_W),
      .SATURATE (SATURATE)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (do_v),
      .dec   (p_dec),
      .count (count)
   );

   sem_waitlist #(
      .NUM_REQ (NUM_REQ)
   ) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .block_en (p_block),
      .block_id (req_id),
      .wake_all (do_v),
      .mask     (blocked_mask),
      .wake     (wake_pulse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q <= '0;
      end else if (wr && req_view == VW_TAG) begin
         tag_q.t <= req_wdata[TAG_T_POS];
         tag_q.f <= req_wdata[TAG_F_POS];
         tag_q.e <= req_wdata[TAG_E_POS];
      end
   end

   always_comb begin
      tag_word            = '0;
      tag_word[TAG_T_POS] = tag_q.t;
      tag_word[TAG_F_POS] = tag_q.f;
      tag_word[TAG_E_POS] = tag_q.e;
   end

   always_comb begin
      rsp_rdata = '0;
      if (rd) begin
         case (req_view)
            VW_RAW, VW_SEM_WAIT, VW_SEM_TRY: rsp_rdata = DATA_W'(count);
            VW_TAG:                          rsp_rdata = tag_word;
            VW_Q_WAIT, VW_Q_TRY:             rsp_rdata = '0;
            default:                         rsp_rdata = '1;
         endcase
      end
   end

   assign rsp_stall = p_block;

   AST_STALL_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_stall |=> (count == '0)); // R2
   AST_TRY_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && req_view == VW_SEM_TRY) |-> !rsp_stall); // R3
   AST_TYPE_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && req_view == VW_TAG) |-> !rsp_rdata[TAG_TYPE_POS]); // R8
   AST_QUEUE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_view == VW_Q_WAIT || req_view == VW_Q_TRY))
         |=> (count == $past(count) && tag_q == $past(tag_q))); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd) |-> (rsp_rdata == '0 && !rsp_stall)); // R11

endmodule

// File: tb/sem_cell_tb.sv
module sem_cell_tb;
   localparam int unsigned CW   = 4;
   localparam int unsigned DW   = 32;
   localparam int unsigned NR   = 8;
   localparam int unsigned IW   = $clog2(NR);
   localparam int unsigned CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [2:0]    req_view = '0;
   logic [IW-1:0] req_id = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_stall;
   logic [NR-1:0] blocked_mask;
   logic [NR-1:0] wake_pulse;

   int checks = 0;
   int fails  = 0;

   // bench model
   int            m_cnt  = 0;
   logic [NR-1:0] m_mask = '0;
   logic [NR-1:0] m_wake = '0;
   logic          m_t = 1'b0, m_f = 1'b0, m_e = 1'b0;

   always #2.5 clk = ~clk;

   sem_cell #(.COUNT_W(CW), .DATA_W(DW), .NUM_REQ(NR)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_view(req_view), .req_id(req_id), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
      .blocked_mask(blocked_mask), .wake_pulse(wake_pulse)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic acc(input string req, input bit w, input int view,
                      input int id, input logic [DW-1:0] d);
      logic [DW-1:0] e_rd;
      logic          e_st;
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_view = 3'(view);
      req_id = IW'(id); req_wdata = d;
      e_rd = '0;
      e_st = 1'b0;
      if (!w) begin
         case (view)
            0, 4, 5: e_rd = DW'(m_cnt);
            1:       e_rd = (DW'(m_t) << 16) | (DW'(m_f) << 1) | DW'(m_e);
            2, 3:    e_rd = '0;
            default: e_rd = '1;
         endcase
         e_st = (view == 4) && (m_cnt == 0);
      end
      #1;
      chk({req, " rdata"}, 64'(rsp_rdata), 64'(e_rd));
      chk({req, " stall"}, 64'(rsp_stall), 64'(e_st));
      m_wake = '0;
      if (!w && (view == 4 || view == 5)) begin
         if (m_cnt > 0) m_cnt--;
         else if (view == 4) m_mask[id] = 1'b1;
      end
      if (w && view == 1) begin
         m_t = d[16]; m_f = d[1]; m_e = d[0];
      end
      if (w && (view == 4 || view == 5)) begin
         if (m_cnt < CMAX) m_cnt++;
         m_wake = m_mask;
         m_mask = '0;
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0; req_write = 1'b0;
      chk({req, " mask"}, 64'(blocked_mask), 64'(m_mask));
      chk({req, " wake"}, 64'(wake_pulse), 64'(m_wake));
   endtask

   initial begin : watchdog
      #200000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R9 reset state
      chk("R9 mask", 64'(blocked_mask), 64'd0);
      chk("R9 wake", 64'(wake_pulse), 64'd0);
      acc("R9 raw count", 1'b0, 0, 0, '0);
      acc("R9 tag", 1'b0, 1, 0, '0);
      // R11 idle outputs
      @(negedge clk); #1;
      chk("R11 idle rdata", 64'(rsp_rdata), 64'd0);
      chk("R11 idle stall", 64'(rsp_stall), 64'd0);
      // R3 try P on zero
      acc("R3 try P zero", 1'b0, 5, 3, '0);
      // R2 every requester blocks in turn
      for (int i = 0; i < NR; i++) acc("R2 wait P zero", 1'b0, 4, i, '0);
      acc("R3 try P zero with waiters", 1'b0, 5, 1, '0);
      // R6 queue views inert
      acc("R6 queue write", 1'b1, 2, 0, 32'hFFFF_FFFF);
      acc("R6 queue try write", 1'b1, 3, 0, 32'hFFFF_FFFF);
      acc("R6 queue read", 1'b0, 2, 0, '0);
      acc("R6 queue try read", 1'b0, 3, 0, '0);
      // R10 undefined views
      acc("R10 view6 write", 1'b1, 6, 0, 32'h1234_5678);
      acc("R10 view6 read", 1'b0, 6, 0, '0);
      acc("R10 view7 read", 1'b0, 7, 0, '0);
      // R7 raw write ignored
      acc("R7 raw write", 1'b1, 0, 0, 32'h0000_0009);
      acc("R7 raw read", 1'b0, 0, 0, '0);
      acc("R8 tag after inert writes", 1'b0, 1, 0, '0);
      // R4 R5 V wakes all, data ignored
      acc("R5 V wakes all", 1'b1, 4, 2, 32'hDEAD_BEEF);
      acc("R4 count after V", 1'b0, 0, 0, '0);
      // R5 wake is one cycle only
      @(negedge clk);
      chk("R5 wake one cycle", 64'(wake_pulse), 64'd0);
      // R4 saturation sweep, mixing sync and try V
      for (int i = 0; i < CMAX + 4; i++) acc("R4 V sweep", 1'b1, 4 + (i % 2), 0, 32'(i));
      acc("R4 saturated count", 1'b0, 0, 0, '0);
      // R1 drain with P reads, then R2/R3 at zero
      for (int i = 0; i < CMAX + 2; i++) acc("R1 P sweep", 1'b0, 4 + (i % 2), i % NR, '0);
      acc("R2 wait P after drain", 1'b0, 4, 5, '0);
      acc("R5 try V wakes", 1'b1, 5, 0, '0);
      acc("R1 P after try V", 1'b0, 4, 6, '0);
      // R8 tag sweep, bit 17 and stray bits set
      for (int i = 0; i < 8; i++) begin
         logic [DW-1:0] d;
         d = 32'hFFFE_FFFC | (DW'(i >> 2) << 16) | DW'(i & 3);
         d[16] = i[2];
         acc("R8 tag write", 1'b1, 1, 0, d);
         acc("R8 tag read", 1'b0, 1, 0, '0);
      end
      acc("R7 raw after tag", 1'b0, 0, 0, '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule